// File: doc/BRIEF.md
# Packed Floating-Point Minimum/Maximum Unit

This block takes two packed vector operands and returns, one clock later, a packed vector in which every lane holds the smaller (or larger) of two floating-point values. Three controls pick the lane format, the vector width and the operation. The lane format is binary32 or binary64. The vector width is the full datapath or its lower half, which is 64 of 128 bits at the default size. The operation is minimum or maximum. A fourth control switches from element-wise operation to a pairwise reduction. In that mode the operands are joined end to end, and each result lane reduces two neighbouring lanes of the joined vector.

Comparison follows the IEEE 754 ordering of sign, exponent and mantissa. A negative zero ranks below a positive zero. Signalling NaNs are quieted and reported, and quiet NaNs pass through by a fixed operand priority. Two sticky flags collect invalid-operation and input-denormal events across all lanes in use. A dedicated input clears them. Instruction decode, register storage, traps, flush-to-zero and rounding modes sit outside the block.

Top module: `fp_minmax_vec`

## Requirements
- R1: While `rst` is high at a rising edge, `res`, `flag_inv` and `flag_den` are zero on the following cycle, whatever the data inputs carry.
- R2: `res` reflects the inputs sampled at the previous rising edge. `lane_dbl`=0 treats each 32-bit slice as one binary32 lane (sign bit 31, exponent bits 30:23, mantissa bits 22:0). `lane_dbl`=1 treats each 64-bit slice as one binary64 lane (sign bit 63, exponent bits 62:52, mantissa bits 51:0).
- R3: With `pair_mode`=0, result lane e is the minimum (`sel_max`=0) or maximum (`sel_max`=1) of lane e of `op_a` (first operand) and lane e of `op_b` (second operand).
- R4: With `pair_mode`=1, the joined vector is {`op_b`,`op_a`} with `op_a` in the low half. Result lane e takes joined lane 2e as its first operand and joined lane 2e+1 as its second operand.
- R5: With `vec_wide`=0, the vector is the low half of the datapath. The result's upper half is zero. For binary64 lanes in this mode, a pairwise reduction combines lane 0 of `op_a` with lane 0 of `op_b`.
- R6: Non-NaN values are ordered by sign first and then by the exponent/mantissa magnitude, with the magnitude order reversed when both values are negative. Minimum returns -0 for the pair (+0, -0), and maximum returns +0.
- R7: NaN handling follows this priority: a signalling NaN in the first operand, a signalling NaN in the second operand, a quiet NaN in the first operand, a quiet NaN in the second operand. A signalling NaN is returned with its top mantissa bit set. A quiet NaN is returned unchanged.
- R8: `flag_inv` becomes 1 after any cycle in which an element consumed by an active lane is a signalling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0).
- R9: `flag_den` becomes 1 after any cycle in which an element consumed by an active lane has a zero exponent and a nonzero mantissa.
- R10: Both flags stay set until `flag_clr` is sampled high. A cycle with `flag_clr` high leaves both flags zero, even if that cycle's operands would raise them.
- R11: With `vec_wide`=0, the upper halves of `op_a` and `op_b` affect neither `res` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | VEC_W | First packed operand |
| op_b | input | VEC_W | Second packed operand |
| lane_dbl | input | 1 | 0: binary32 lanes, 1: binary64 lanes |
| vec_wide | input | 1 | 0: low half of the datapath only, 1: full width |
| sel_max | input | 1 | 0: minimum, 1: maximum |
| pair_mode | input | 1 | 1: pairwise reduction of the joined operands |
| flag_clr | input | 1 | Clears both sticky flags |
| res | output | VEC_W | Registered packed result |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_den | output | 1 | Sticky input-denormal flag |

## Verification
Four behaviours are checked by the assertions on every cycle. The upper half of the result stays zero in the narrow width. A clear leaves both flags at zero. A set flag holds until cleared. Inputs held constant give a constant result. The value rules can only be shown by the bench's sweeps, because they need a reference ordering of the values. These rules are the ordering itself, the signed-zero ranking, the NaN priority and quieting, and the lane pairing in pairwise mode. Three further behaviours also need directed scenarios: which lanes feed the flags, whether the inactive upper half is ignored, and the binary32 against binary64 reading of the same bits.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;

  typedef struct packed {
    logic inv;
    logic den;
  } fpmm_flags_t;
endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
  parameter int EW = 8,
  parameter int MW = 23,
  localparam int W = EW + MW + 1
) (
  input  logic [W-1:0]          x,
  input  logic [W-1:0]          y,
  input  logic                  is_max,
  output logic [W-1:0]          z,
  output fpmm_pkg::fpmm_flags_t flg
);
  localparam logic [W-1:0] QBIT = {{(W-MW){1'b0}}, 1'b1, {(MW-1){1'b0}}};

  logic [EW-1:0] xe, ye;
  logic [MW-1:0] xm, ym;
  logic x_nan, y_nan, x_sig, y_sig, x_den, y_den;
  logic x_lt, take_x;

  assign xe = x[W-2 -: EW];
  assign ye = y[W-2 -: EW];
  assign xm = x[MW-1:0];
  assign ym = y[MW-1:0];

  assign x_nan = (&xe) && (|xm);
  assign y_nan = (&ye) && (|ym);
  assign x_sig = x_nan && !xm[MW-1];
  assign y_sig = y_nan && !ym[MW-1];
  assign x_den = (~|xe) && (|xm);
  assign y_den = (~|ye) && (|ym);

  // ordered compare: sign first, magnitude reversed for two negatives
  always_comb begin
    if (x[W-1] != y[W-1])
      x_lt = x[W-1];
    else if (x[W-1])
      x_lt = x[W-2:0] > y[W-2:0];
    else
      x_lt = x[W-2:0] < y[W-2:0];
  end

  assign take_x = is_max ? !x_lt : x_lt;

  always_comb begin
    if (x_sig)      z = x | QBIT;
    else if (y_sig) z = y | QBIT;
    else if (x_nan) z = x;
    else if (y_nan) z = y;
    else            z = take_x ? x : y;
  end

  assign flg.inv = x_sig | y_sig;
  assign flg.den = x_den | y_den;
endmodule

// File: rtl/fpmm_bank.sv
module fpmm_bank #(
  parameter int VEC_W = 128,
  parameter int EW    = 8,
  parameter int MW    = 23
) (
  input  logic [VEC_W-1:0]      a,
  input  logic [VEC_W-1:0]      b,
  input  logic                  wide,
  input  logic                  pair,
  input  logic                  is_max,
  output logic [VEC_W-1:0]      z,
  output fpmm_pkg::fpmm_flags_t flg
);
  localparam int ESZ  = EW + MW + 1;
  localparam int NL   = VEC_W / ESZ;
  localparam int HALF = VEC_W / 2;

  logic [2*VEC_W-1:0] joined;
  logic [NL-1:0]      inv_l, den_l;

  assign joined = wide ? {b, a} : {{VEC_W{1'b0}}, b[HALF-1:0], a[HALF-1:0]};

  for (genvar e = 0; e < NL; e++) begin : g_lane
    logic [ESZ-1:0]        xl, yl, zl;
    fpmm_pkg::fpmm_flags_t fl;
    logic                  act;

    assign act = wide || (e < NL/2);
    assign xl  = pair ? joined[(2*e)*ESZ +: ESZ]   : a[e*ESZ +: ESZ];
    assign yl  = pair ? joined[(2*e+1)*ESZ +: ESZ] : b[e*ESZ +: ESZ];

    fpmm_lane #(.EW(EW), .MW(MW)) u_lane (
      .x(xl), .y(yl), .is_max(is_max), .z(zl), .flg(fl)
    );

    assign z[e*ESZ +: ESZ] = act ? zl : '0;
    assign inv_l[e] = act & fl.inv;
    assign den_l[e] = act & fl.den;
  end

  assign flg.inv = |inv_l;
  assign flg.den = |den_l;
endmodule

// File: rtl/fp_minmax_vec.sv
module fp_minmax_vec #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic             lane_dbl,
  input  logic             vec_wide,
  input  logic             sel_max,
  input  logic             pair_mode,
  input  logic             flag_clr,
  output logic [VEC_W-1:0] res,
  output logic             flag_inv,
  output logic             flag_den
);
  import fpmm_pkg::*;

  logic [VEC_W-1:0] sp_z, dp_z, nxt_z;
  fpmm_flags_t      sp_f, dp_f, nxt_f;

  fpmm_bank #(.VEC_W(VEC_W), .EW(SP_EXP), .MW(SP_MAN)) u_sp (
    .a(op_a), .b(op_b), .wide(vec_wide), .pair(pair_mode),
    .is_max(sel_max), .z(sp_z), .flg(sp_f)
  );

  fpmm_bank #(.VEC_W(VEC_W), .EW(DP_EXP), .MW(DP_MAN)) u_dp (
    .a(op_a), .b(op_b), .wide(vec_wide), .pair(pair_mode),
    .is_max(sel_max), .z(dp_z), .flg(dp_f)
  );

  assign nxt_z = lane_dbl ? dp_z : sp_z;
  assign nxt_f = lane_dbl ? dp_f : sp_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      flag_inv <= 1'b0;
      flag_den <= 1'b0;
    end else begin
      res      <= nxt_z;
      flag_inv <= flag_clr ? 1'b0 : (flag_inv | nxt_f.inv);
      flag_den <= flag_clr ? 1'b0 : (flag_den | nxt_f.den);
    end
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic             lane_dbl,
  input logic             vec_wide,
  input logic             sel_max,
  input logic             pair_mode,
  input logic             flag_clr,
  input logic [VEC_W-1:0] res,
  input logic             flag_inv,
  input logic             flag_den
);
  localparam int HALF = VEC_W / 2;

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !vec_wide |=> (res[VEC_W-1:HALF] == '0)); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (!flag_inv && !flag_den)); // R10

  AST_INV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_inv && !flag_clr) |=> flag_inv); // R10

  AST_DEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_den && !flag_clr) |=> flag_den); // R10

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($stable(rst) && $stable(op_a) && $stable(op_b) && $stable(lane_dbl) &&
     $stable(vec_wide) && $stable(sel_max) && $stable(pair_mode))
    |=> $stable(res)); // R2
endmodule

bind fp_minmax_vec fpmm_chk #(.VEC_W(VEC_W)) u_fpmm_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .lane_dbl(lane_dbl),
  .vec_wide(vec_wide), .sel_max(sel_max), .pair_mode(pair_mode),
  .flag_clr(flag_clr), .res(res), .flag_inv(flag_inv), .flag_den(flag_den)
);

// File: tb/test_fp_minmax_vec.sv
module test_fp_minmax_vec;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic [VW-1:0] op_a, op_b, res;
  logic          lane_dbl, vec_wide, sel_max, pair_mode, flag_clr;
  logic          flag_inv, flag_den;
  int            n_chk = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;

  fp_minmax_vec #(.VEC_W(VW)) i_fp_minmax_vec (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .lane_dbl(lane_dbl),
    .vec_wide(vec_wide), .sel_max(sel_max), .pair_mode(pair_mode),
    .flag_clr(flag_clr), .res(res), .flag_inv(flag_inv), .flag_den(flag_den)
  );

  function automatic logic [63:0] sval(int idx, bit dbl);
    if (!dbl) begin
      case (idx)
        0: return 64'h0000_0000;  1: return 64'h8000_0000;
        2: return 64'h3F80_0000;  3: return 64'hBF80_0000;
        4: return 64'h3FC0_0000;  5: return 64'hC000_0000;
        6: return 64'h7F80_0000;  7: return 64'hFF80_0000;
        8: return 64'h0000_0001;  9: return 64'h807F_FFFF;
        10: return 64'h7FC0_0001; 11: return 64'hFFC0_0002;
        12: return 64'h7F80_0005; 13: return 64'hFF80_0003;
        14: return 64'h7F7F_FFFF; default: return 64'h8080_0000;
      endcase
    end else begin
      case (idx)
        0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
        2: return 64'h3FF0_0000_0000_0000;  3: return 64'hBFF0_0000_0000_0000;
        4: return 64'h3FF8_0000_0000_0000;  5: return 64'hC000_0000_0000_0000;
        6: return 64'h7FF0_0000_0000_0000;  7: return 64'hFFF0_0000_0000_0000;
        8: return 64'h0000_0000_0000_0001;  9: return 64'h800F_FFFF_FFFF_FFFF;
        10: return 64'h7FF8_0000_0000_0001; 11: return 64'hFFF8_0000_0000_0002;
        12: return 64'h7FF0_0000_0000_0005; 13: return 64'hFFF0_0000_0000_0003;
        14: return 64'h7FEF_FFFF_FFFF_FFFF; default: return 64'h8010_0000_0000_0000;
      endcase
    end
  endfunction

  // reference lane: order via monotone integer key, NaN priority from the requirements
  function automatic logic [63:0] ref_lane(input logic [63:0] x, input logic [63:0] y,
                                           input bit dbl, input bit mx,
                                           inout bit inv, inout bit den);
    logic [63:0] em, mm, qb, sg, full, kx, ky;
    bit xn, yn, xs, ys;
    em   = dbl ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000;
    mm   = dbl ? 64'h000F_FFFF_FFFF_FFFF : 64'h007F_FFFF;
    qb   = dbl ? 64'h0008_0000_0000_0000 : 64'h0040_0000;
    sg   = dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    full = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    xn = ((x & em) == em) && ((x & mm) != 0);
    yn = ((y & em) == em) && ((y & mm) != 0);
    xs = xn && ((x & qb) == 0);
    ys = yn && ((y & qb) == 0);
    if (xs || ys) inv = 1'b1;
    if ((((x & em) == 0) && ((x & mm) != 0)) || (((y & em) == 0) && ((y & mm) != 0))) den = 1'b1;
    if (xs) return x | qb;
    if (ys) return y | qb;
    if (xn) return x;
    if (yn) return y;
    kx = ((x & sg) != 0) ? (~x & full) : (x | sg);
    ky = ((y & sg) != 0) ? (~y & full) : (y | sg);
    if (mx) return (ky > kx) ? y : x;
    return (ky < kx) ? y : x;
  endfunction

  function automatic void ref_vec(input logic [127:0] a, input logic [127:0] b,
                                  input bit dbl, input bit wide, input bit mx, input bit pair,
                                  output logic [127:0] r, output bit inv, output bit den);
    int esz, nl;
    logic [63:0]  m;
    logic [319:0] cat;
    logic [191:0] ap, bp;
    esz = dbl ? 64 : 32;
    nl  = (wide ? 128 : 64) / esz;
    m   = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    cat = wide ? {64'b0, b, a} : {192'b0, b[63:0], a[63:0]};
    ap  = {64'b0, a};
    bp  = {64'b0, b};
    r = '0; inv = 1'b0; den = 1'b0;
    for (int e = 0; e < nl; e++) begin
      logic [63:0] x, y, z;
      if (pair) begin
        x = cat[(2*e)*esz +: 64] & m;
        y = cat[(2*e+1)*esz +: 64] & m;
      end else begin
        x = ap[e*esz +: 64] & m;
        y = bp[e*esz +: 64] & m;
      end
      z = ref_lane(x, y, dbl, mx, inv, den);
      r = r | ({64'b0, z} << (e*esz));
    end
  endfunction

  task automatic step(input logic [127:0] a, input logic [127:0] b, input bit dbl,
                      input bit wide, input bit mx, input bit pair, input bit clr);
    op_a = a; op_b = b; lane_dbl = dbl; vec_wide = wide;
    sel_max = mx; pair_mode = pair; flag_clr = clr;
    @(negedge clk);
  endtask

  task automatic chk_v(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_b(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] a, b, er;
    bit ei, ed;
    rst = 1'b1;
    op_a = {4{32'h7F80_0005}}; op_b = {4{32'h0000_0001}};
    lane_dbl = 1'b0; vec_wide = 1'b1; sel_max = 1'b0; pair_mode = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk_v("R1 reset res", res, '0);
    chk_b("R1 reset inv", flag_inv, 1'b0);
    chk_b("R1 reset den", flag_den, 1'b0);
    rst = 1'b0;
    step('0, '0, 0, 1, 0, 0, 1);

    // R2: same bits read as one binary64 lane, not two binary32 lanes
    step('0, '0, 0, 1, 0, 0, 1);
    step({64'h0, 64'h3FF0_0000_FFFF_FFFF}, {64'h0, 64'h4000_0000_0000_0000}, 1, 0, 0, 0, 0);
    chk_v("R2 binary64 lane", res, {64'h0, 64'h3FF0_0000_FFFF_FFFF});
    chk_b("R2 no invalid", flag_inv, 1'b0);

    // R5: narrow binary64 pairwise reduces A lane 0 with B lane 0
    step('0, '0, 0, 1, 0, 0, 1);
    step({64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000},
         {64'hFFF0_0000_0000_0001, 64'hC000_0000_0000_0000}, 1, 0, 1, 1, 0);
    chk_v("R5 narrow pair max", res, {64'h0, 64'h3FF0_0000_0000_0000});

    // R6: signed zero ordering
    step({4{32'h0000_0000}}, {4{32'h8000_0000}}, 0, 1, 0, 0, 1);
    chk_v("R6 min zeros sp", res, {4{32'h8000_0000}});
    step({4{32'h0000_0000}}, {4{32'h8000_0000}}, 0, 1, 1, 0, 1);
    chk_v("R6 max zeros sp", res, {4{32'h0000_0000}});
    step({2{64'h8000_0000_0000_0000}}, {2{64'h0}}, 1, 1, 0, 0, 1);
    chk_v("R6 min zeros dp", res, {2{64'h8000_0000_0000_0000}});

    // R7: NaN priority
    step('0, '0, 0, 1, 0, 0, 1);
    step({96'h0, 32'h7FC0_0001}, {96'h0, 32'h7F80_0005}, 0, 1, 0, 0, 0);
    chk_v("R7 sNaN second beats qNaN first", res, {96'h0, 32'h7FC0_0005});
    chk_b("R8 sNaN raises invalid", flag_inv, 1'b1);
    step({96'h0, 32'hFFC0_0002}, {96'h0, 32'h7FC0_0001}, 0, 1, 1, 0, 1);
    chk_v("R7 qNaN first wins", res, {96'h0, 32'hFFC0_0002});

    // R10: sticky, then clear beats a simultaneous event
    step('0, '0, 0, 1, 0, 0, 1);
    step({96'h0, 32'h7F80_0005}, {96'h0, 32'h0000_0001}, 0, 1, 0, 0, 0);
    step({96'h0, 32'h3F80_0000}, {96'h0, 32'h4000_0000}, 0, 1, 0, 0, 0);
    chk_b("R10 inv sticky", flag_inv, 1'b1);
    chk_b("R10 den sticky", flag_den, 1'b1);
    step({96'h0, 32'h7F80_0005}, {96'h0, 32'h0000_0001}, 0, 1, 0, 0, 1);
    chk_b("R10 clear priority inv", flag_inv, 1'b0);
    chk_b("R10 clear priority den", flag_den, 1'b0);

    // R11: upper half ignored in narrow width
    step('0, '0, 0, 1, 0, 0, 1);
    step({{2{32'h7F80_0005}}, 32'h3F80_0000, 32'h4000_0000},
         {{2{32'h0000_0001}}, 32'h4000_0000, 32'h3F80_0000}, 0, 0, 0, 0, 0);
    chk_v("R11 narrow result", res, {64'h0, 32'h3F80_0000, 32'h3F80_0000});
    chk_b("R11 narrow inv", flag_inv, 1'b0);
    chk_b("R11 narrow den", flag_den, 1'b0);

    // sweep all value pairs under every control combination
    for (int cfg = 0; cfg < 16; cfg++) begin
      bit dbl, wide, pair, mx;
      int esz;
      dbl = cfg[0]; wide = cfg[1]; pair = cfg[2]; mx = cfg[3];
      esz = dbl ? 64 : 32;
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          string tg;
          a = '0; b = '0;
          for (int k = 0; k < 128/esz; k++) begin
            a = a | ({64'b0, sval((i + 3*k) % 16, dbl)} << (k*esz));
            b = b | ({64'b0, sval((j + 5*k) % 16, dbl)} << (k*esz));
          end
          ref_vec(a, b, dbl, wide, mx, pair, er, ei, ed);
          step('0, '0, dbl, wide, mx, pair, 1);
          step(a, b, dbl, wide, mx, pair, 0);
          tg = $sformatf("dbl=%0d wide=%0d pair=%0d max=%0d i=%0d j=%0d", dbl, wide, pair, mx, i, j);
          chk_v({pair ? "R4 " : "R3 ", tg}, res, er);
          chk_b({"R8 ", tg}, flag_inv, ei);
          chk_b({"R9 ", tg}, flag_den, ed);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule